// File: doc/BRIEF.md
# Shared-Bus Register Transfer Datapath

This block is the register and bus half of a small accumulator machine. Six registers and an external memory word share one 16-bit transfer bus. A 3-bit select code chooses which source drives the bus in a cycle. Any number of registers may capture that bus value at the next clock edge. The address and program-counter registers are 12 bits wide. They are zero-extended when they drive the bus and keep only the low 12 bits when they load. A control sequencer outside the block drives the select code, a per-register load/increment/clear mask and a memory write strobe.

The memory array is outside the block. Its address lines come straight from the address register and never from the bus. Its write data is the current bus value, so a store is a single-cycle transfer from whichever register is selected. The instruction register accepts loads only. The other five registers can also count up by one or clear to zero.

Top module: `bus_xfer_datapath`

## Requirements
- R1: While `rst_n` is low at a clock edge, all six registers become zero, whatever the other inputs are.
- R2: The bus carries zero for select code 0, the address register for 1, the program counter for 2, the data register for 3, the accumulator for 4, the instruction register for 5, the temporary register for 6 and `mem_rdata` for 7.
- R3: A register whose load bit is set captures the bus value at the next rising edge, and several registers may load in the same cycle. Mask bit positions are: bit 0 address register, bit 1 program counter, bit 2 data register, bit 3 accumulator, bit 4 instruction register, bit 5 temporary register.
- R4: When the address register or the program counter drives the bus, bus bits 15:12 are zero.
- R5: When the address register or the program counter loads, it takes bus bits 11:0 and drops the top four bits.
- R6: An increment adds one modulo the register width: 16'hFFFF wraps to 0 and 12'hFFF wraps to 0.
- R7: On one register, clear outranks load and load outranks increment.
- R8: The instruction register ignores its increment and clear bits, and its value changes only on a load.
- R9: `mem_addr` always equals the address register. `mem_we` follows `mem_wr`, and `mem_wdata` is the bus value of that cycle.
- R10: A register with no control bit set keeps its value.
- R11: A register that drives the bus while it is incremented or cleared in the same cycle hands its old value to the destinations and to a memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 3 | Bus source select code |
| reg_ld | input | 6 | Per-register load mask |
| reg_inc | input | 6 | Per-register increment mask |
| reg_clr | input | 6 | Per-register clear mask |
| mem_wr | input | 1 | Request to store the bus value in memory |
| mem_rdata | input | 16 | Memory word at `mem_addr` |
| mem_addr | output | 12 | Memory address, taken from the address register |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data, the bus value |
| bus_value | output | 16 | Current bus value |
| ar_q | output | 12 | Address register |
| pc_q | output | 12 | Program counter |
| dr_q | output | 16 | Data register |
| ac_q | output | 16 | Accumulator |
| ir_q | output | 16 | Instruction register |
| tr_q | output | 16 | Temporary register |

## Verification
Two functions can fall in the same cycle: a register driving the bus while it counts or clears, and other registers or memory capturing that bus value. The bench provokes this in three ways. It selects the program counter while the address register loads and the program counter increments. It selects the accumulator while the accumulator clears and a memory write is requested. It then reads that memory word back. The destinations and the stored word are judged against the source's pre-edge value, and the source register is judged against its counted or cleared value.

// File: rtl/xfer_pkg.sv
// Shared widths, register indices and bus source codes for the transfer datapath.
// Assumes: the index of each register in the control masks is fixed by these constants.
package xfer_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 16;
    localparam int NREG   = 6;
    localparam int SEL_W  = $clog2(NREG + 2);

    localparam int IDX_AR = 0;
    localparam int IDX_PC = 1;
    localparam int IDX_DR = 2;
    localparam int IDX_AC = 3;
    localparam int IDX_IR = 4;
    localparam int IDX_TR = 5;

    typedef enum logic [SEL_W-1:0] {
        SRC_NONE = 3'd0,
        SRC_AR   = 3'd1,
        SRC_PC   = 3'd2,
        SRC_DR   = 3'd3,
        SRC_AC   = 3'd4,
        SRC_IR   = 3'd5,
        SRC_TR   = 3'd6,
        SRC_MEM  = 3'd7
    } bus_src_e;
endpackage

// File: rtl/xfer_reg.sv
// One bus destination register.
// With COUNTABLE set, it clears, loads or counts up, in that priority order.
// With COUNTABLE clear, it only loads, and its increment and clear inputs have no effect.
// Assumes: d is already cut to WIDTH bits by the caller, and reset is synchronous and active low.
module xfer_reg #(
    parameter int WIDTH     = 16,
    parameter bit COUNTABLE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic             inc,
    input  logic             clr,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        if (COUNTABLE) begin : g_count
            // Update the register: reset, then clear, then load, then increment.
            always_ff @(posedge clk) begin
                if (!rst_n)     q <= '0;
                else if (clr)   q <= '0;
                else if (ld)    q <= d;
                else if (inc)   q <= q + 1'b1;
            end

            assert_clr_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
                clr |=> (q == '0));
            assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (ld && !clr) |=> (q == $past(d)));
            assert_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (inc && !ld && !clr) |=> (q == WIDTH'($past(q) + 1'b1)));
            assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (!ld && !inc && !clr) |=> $stable(q));
        end else begin : g_load_only
            // Update the register: reset, then load. Nothing else changes it.
            always_ff @(posedge clk) begin
                if (!rst_n)     q <= '0;
                else if (ld)    q <= d;
            end

            assert_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
                ((inc || clr) && !ld) |=> $stable(q));
            assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
                ld |=> (q == $past(d)));
        end
    endgenerate
endmodule

// File: rtl/bus_mux.sv
// Source selector for the shared bus.
// Code 0 gives zeros, codes 1..NREG pick a register, and code NREG+1 picks the memory word.
// Assumes: the register sources arrive already zero-extended to DATA_W.
module bus_mux #(
    parameter int DATA_W = 16,
    parameter int NREG   = 6,
    parameter int SEL_W  = 3
) (
    input  logic [SEL_W-1:0]             sel,
    input  logic [NREG-1:0][DATA_W-1:0]  src,
    input  logic [DATA_W-1:0]            mem_rd,
    output logic [DATA_W-1:0]            bus
);
    // Pick the one selected source; an unused code gives all zeros.
    always_comb begin
        bus = '0;
        if (sel == SEL_W'(NREG + 1)) begin
            bus = mem_rd;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (sel == SEL_W'(i + 1)) bus = src[i];
            end
        end
    end
endmodule

// File: rtl/bus_xfer_datapath.sv
// Register transfer datapath built around one shared bus.
// It holds six destination registers, the source selector and the width adaptation
// between 12-bit and 16-bit registers.
// Assumes: the external memory returns mem_rdata for mem_addr in the same cycle
// and writes mem_wdata at mem_addr on a rising edge when mem_we is high.
module bus_xfer_datapath
    import xfer_pkg::*;
#(
    parameter int AW = xfer_pkg::ADDR_W,
    parameter int DW = xfer_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  bus_sel,
    input  logic [NREG-1:0]   reg_ld,
    input  logic [NREG-1:0]   reg_inc,
    input  logic [NREG-1:0]   reg_clr,
    input  logic              mem_wr,
    input  logic [DW-1:0]     mem_rdata,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_we,
    output logic [DW-1:0]     mem_wdata,
    output logic [DW-1:0]     bus_value,
    output logic [AW-1:0]     ar_q,
    output logic [AW-1:0]     pc_q,
    output logic [DW-1:0]     dr_q,
    output logic [DW-1:0]     ac_q,
    output logic [DW-1:0]     ir_q,
    output logic [DW-1:0]     tr_q
);
    logic [NREG-1:0][DW-1:0] reg_wide;
    logic [DW-1:0]           bus;

    bus_mux #(.DATA_W(DW), .NREG(NREG), .SEL_W(SEL_W)) u_mux (
        .sel    (bus_sel),
        .src    (reg_wide),
        .mem_rd (mem_rdata),
        .bus    (bus)
    );

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_reg
            localparam int W = (i == IDX_AR || i == IDX_PC) ? AW : DW;
            logic [W-1:0] q_n;

            xfer_reg #(.WIDTH(W), .COUNTABLE(i != IDX_IR)) u_reg (
                .clk   (clk),
                .rst_n (rst_n),
                .ld    (reg_ld[i]),
                .inc   (reg_inc[i]),
                .clr   (reg_clr[i]),
                .d     (bus[W-1:0]),
                .q     (q_n)
            );

            // Zero-extend the register so that it can drive the full-width bus.
            assign reg_wide[i] = DW'(q_n);
        end
    endgenerate

    // Bring the registers and the memory side out to the ports.
    assign ar_q      = reg_wide[IDX_AR][AW-1:0];
    assign pc_q      = reg_wide[IDX_PC][AW-1:0];
    assign dr_q      = reg_wide[IDX_DR];
    assign ac_q      = reg_wide[IDX_AC];
    assign ir_q      = reg_wide[IDX_IR];
    assign tr_q      = reg_wide[IDX_TR];
    assign mem_addr  = ar_q;
    assign mem_we    = mem_wr;
    assign mem_wdata = bus;
    assign bus_value = bus;

    assert_zero_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel == SRC_AR || bus_sel == SRC_PC) |-> (bus[DW-1:AW] == '0));
    assert_sel_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel == SRC_NONE) |-> (bus_value == '0));
endmodule

// File: tb/tb_bus_xfer_datapath.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task predicts register contents and queues them,
// and the monitor compares them just after each rising edge.
module tb_bus_xfer_datapath;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_sel = '0;
    logic [5:0]  reg_ld = '0, reg_inc = '0, reg_clr = '0;
    logic        mem_wr = 1'b0;
    logic [15:0] mem_rdata, mem_wdata, bus_value, dr_q, ac_q, ir_q, tr_q;
    logic [11:0] mem_addr, ar_q, pc_q;
    logic        mem_we;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    logic [15:0] mem   [256];
    logic [15:0] m_mem [256];
    logic [15:0] m_r   [6];
    logic [95:0] exp_q [$];
    string       tag_q [$];

    bus_xfer_datapath dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .reg_ld(reg_ld),
        .reg_inc(reg_inc), .reg_clr(reg_clr), .mem_wr(mem_wr),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .bus_value(bus_value), .ar_q(ar_q),
        .pc_q(pc_q), .dr_q(dr_q), .ac_q(ac_q), .ir_q(ir_q), .tr_q(tr_q)
    );

    always #2.5 clk = ~clk;

    function automatic logic [15:0] seed(int i);
        if (i == 0)   return 16'h70FF;
        if (i == 255) return 16'hFFFF;
        return 16'((i * 16'h0139) ^ 16'hC35A);
    endfunction

    // Memory model: filled while reset is low, and written on a strobe afterwards.
    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= seed(i);
        end else if (mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata;
        end
    end

    function automatic logic [95:0] pack_model();
        return {m_r[5], m_r[4], m_r[3], m_r[2], m_r[1], m_r[0]};
    endfunction

    // Drive one transfer cycle, predict its outcome and queue the prediction.
    task automatic step(input logic [2:0] sel, input logic [5:0] ld, inc, clr,
                        input logic wr, input string tag);
        logic [15:0] b;
        logic [15:0] nr [6];
        @(negedge clk);
        bus_sel = sel; reg_ld = ld; reg_inc = inc; reg_clr = clr; mem_wr = wr;
        if (sel == 3'd0)      b = 16'h0000;
        else if (sel == 3'd7) b = m_mem[m_r[0][7:0]];
        else                  b = m_r[sel - 3'd1];
        for (int i = 0; i < 6; i++) begin
            logic [15:0] mask;
            bit cnt;
            mask = (i < 2) ? 16'h0FFF : 16'hFFFF;
            cnt  = (i != 4);
            if (cnt && clr[i])      nr[i] = 16'h0000;
            else if (ld[i])         nr[i] = b & mask;
            else if (cnt && inc[i]) nr[i] = (m_r[i] + 16'd1) & mask;
            else                    nr[i] = m_r[i];
        end
        if (wr) m_mem[m_r[0][7:0]] = b;
        for (int i = 0; i < 6; i++) m_r[i] = nr[i];
        exp_q.push_back(pack_model());
        tag_q.push_back(tag);
        #1;
        n_cmp++;
        if (bus_value !== b) begin
            n_bad++;
            $display("FAIL %s (bus, R2): actual %h expected %h", tag, bus_value, b);
        end
    endtask

    // Monitor: just after each edge, compare the registers with the oldest prediction.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [95:0] e, a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {tr_q, ir_q, ac_q, dr_q, {4'h0, pc_q}, {4'h0, ar_q}};
                n_cmp++;
                if (a !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", t, a, e);
                end
            end
        end
    end

    initial begin
        #50000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) m_mem[i] = seed(i);
        for (int i = 0; i < 6; i++) m_r[i] = 16'h0000;
        // R1: reset holds every register at zero even with all controls asserted.
        @(negedge clk);
        bus_sel = 3'd7; reg_ld = '1; reg_inc = '1;
        exp_q.push_back(96'h0);
        tag_q.push_back("R1 reset clears");
        @(negedge clk);
        rst_n = 1'b1; bus_sel = '0; reg_ld = '0; reg_inc = '0;

        step(3'd7, 6'b000001, 6'd0, 6'd0, 1'b0, "R5 AR loads low bits from memory");
        step(3'd7, 6'b100100, 6'd0, 6'd0, 1'b0, "R3 DR and TR load together");
        step(3'd3, 6'b001000, 6'd0, 6'd0, 1'b0, "R2 DR to AC");
        step(3'd6, 6'b010000, 6'd0, 6'd0, 1'b0, "R2 TR to IR");
        step(3'd5, 6'b000010, 6'd0, 6'd0, 1'b0, "R5 IR to PC keeps low bits");
        step(3'd0, 6'd0, 6'b111111, 6'b010000, 1'b0, "R6 R8 count with wrap, IR ignores inc and clr");
        step(3'd7, 6'b000100, 6'd0, 6'd0, 1'b0, "R9 read at address register");
        step(3'd3, 6'b101000, 6'd0, 6'd0, 1'b0, "R3 DR to AC and TR");
        step(3'd5, 6'b000010, 6'd0, 6'd0, 1'b0, "R5 PC from IR");
        step(3'd2, 6'b001000, 6'd0, 6'd0, 1'b0, "R4 PC drives bus zero-extended");
        step(3'd1, 6'b100000, 6'd0, 6'd0, 1'b0, "R4 AR drives bus zero-extended");
        step(3'd0, 6'b000100, 6'd0, 6'd0, 1'b0, "R2 code 0 loads zero");
        step(3'd3, 6'b001000, 6'b001000, 6'b001000, 1'b0, "R7 clear beats load and increment");
        step(3'd6, 6'b000100, 6'b000100, 6'd0, 1'b0, "R7 load beats increment");
        step(3'd2, 6'b000001, 6'b000010, 6'd0, 1'b0, "R11 PC drives AR while counting");
        step(3'd6, 6'b001000, 6'd0, 6'd0, 1'b0, "R3 TR to AC");
        step(3'd4, 6'd0, 6'd0, 6'b001000, 1'b1, "R11 R9 store old AC while clearing");
        step(3'd7, 6'b000100, 6'd0, 6'd0, 1'b0, "R9 read back stored word");
        step(3'd7, 6'd0, 6'd0, 6'd0, 1'b0, "R10 no control holds");
        step(3'd3, 6'b010000, 6'd0, 6'b010000, 1'b0, "R8 IR loads despite clear");
        step(3'd5, 6'd0, 6'd0, 6'd0, 1'b0, "R2 IR on bus");

        @(negedge clk);
        bus_sel = '0; reg_ld = '0; reg_inc = '0; reg_clr = '0; mem_wr = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule